// File: doc/BRIEF.md
# Banked Bit-Toggle Execute Unit

This block carries out one bit-inversion instruction against a small banked byte memory. A 16-bit instruction word arrives with a one-cycle start strobe. The unit pulls a bit number, a bank-mode flag and an 8-bit file address out of the word. It builds a full memory address in one of three ways: a fixed split access bank, a bank picked by the bank-select input, or an index register plus a literal offset. It then reads the byte, flips the chosen bit and stores the byte back.

The work runs as a fixed sequence of four phases (decode, read, process, write), followed by a single done pulse. The memory port is a plain synchronous RAM interface: read data arrives one clock after the read strobe. Start strobes that arrive while a sequence is running are dropped. No flags or status are produced.

Top module: `btg_exec_unit`

## Requirements
- R1: A start is accepted only when instr[15:12] equals 4'b0111. Any other opcode causes no busy, no read strobe and no write strobe.
- R2: The field positions in instr are fixed as follows. instr[11:9] is the bit index, instr[8] is the bank-mode flag and instr[7:0] is the file address. The byte written back equals the byte read with only that bit index inverted. For example, 0x75 with bit 4 toggled becomes 0x65.
- R3: When instr[8] is 1, the memory address is {bank_sel, file address}.
- R4: When instr[8] is 0 and indexing does not apply, the address depends only on the file address. Files 0x00 to 0x5F map to bank 0. Files 0x60 to 0xFF map to the top bank, which has all bank bits set.
- R5: When instr[8] is 0, ext_en is 1 and the file address is at most 0x5F, the address is index_reg plus the file address, truncated to ADDR_W bits.
- R6: The sequence runs on fixed cycles counted from the accepting clock edge. The first cycle after it is the decode phase with no strobes. The second cycle carries mem_rd_en, the third has no strobes and the fourth carries mem_wr_en. The fifth cycle has done high for exactly one cycle. busy is high from the decode phase through the done cycle, and the unit is idle on the sixth cycle.
- R7: A start strobe while busy is high is ignored.
- R8: instr, bank_sel, index_reg and ext_en are sampled only at the accepting edge. Later changes do not alter the address or the data.
- R9: During and after reset the unit is idle: busy, done, mem_rd_en and mem_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run instr |
| instr | input | 16 | Instruction word |
| ext_en | input | 1 | Enables indexed literal-offset addressing |
| bank_sel | input | BANK_W (3) | Bank used when instr[8] is 1 |
| index_reg | input | ADDR_W (11) | Base address for indexed mode |
| mem_addr | output | ADDR_W (11) | RAM address |
| mem_rd_en | output | 1 | RAM read strobe; data returns next cycle |
| mem_rdata | input | 8 | RAM read data |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle. The write strobe follows the read strobe by exactly two cycles, at the same address. The written byte differs from the read byte in exactly one bit. done is a single-cycle pulse that follows the write, and busy holds until done. The phases never skip or reorder. Which address each mode selects, the boundary at file 0x5F/0x60, wrap-around of the indexed sum, and the rejection of bad opcodes, late starts and changed inputs can only be shown by the bench scenarios, which compare against a reference memory.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DECODE = 3'd1,
    PH_READ   = 3'd2,
    PH_PROC   = 3'd3,
    PH_WRITE  = 3'd4,
    PH_DONE   = 3'd5
  } phase_t;

  localparam logic [3:0] OPC_TOGGLE = 4'b0111;
  localparam logic [7:0] LIT_LIMIT  = 8'h5F;
endpackage

// File: rtl/btg_decode.sv
module btg_decode #(
  parameter int DATA_W = 8,
  parameter int FILE_W = 8,
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0]         instr,
  output logic                       is_toggle,
  output logic                       bank_mode,
  output logic [FILE_W-1:0]          file_addr,
  output logic [DATA_W-1:0]          bit_mask
);
  import btg_pkg::*;
  localparam int BIT_W = $clog2(DATA_W);

  logic [BIT_W-1:0] bit_idx;

  assign is_toggle = (instr[INSTR_W-1 -: 4] == OPC_TOGGLE);
  assign bit_idx   = instr[FILE_W+1 +: BIT_W];
  assign bank_mode = instr[FILE_W];
  assign file_addr = instr[FILE_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign bit_mask[i] = (bit_idx == BIT_W'(i));
  end
endmodule

// File: rtl/btg_addr_gen.sv
module btg_addr_gen #(
  parameter int BANK_W = 3,
  parameter int FILE_W = 8
) (
  input  logic                     bank_mode,
  input  logic                     ext_en,
  input  logic [FILE_W-1:0]        file_addr,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [BANK_W+FILE_W-1:0] index_reg,
  output logic [BANK_W+FILE_W-1:0] addr
);
  import btg_pkg::*;
  localparam int ADDR_W = BANK_W + FILE_W;

  logic [ADDR_W-1:0] indexed_sum;
  logic              low_half;

  assign indexed_sum = index_reg + {{BANK_W{1'b0}}, file_addr};
  assign low_half    = (file_addr <= FILE_W'(LIT_LIMIT));

  always_comb begin
    if (bank_mode) begin
      addr = {bank_sel, file_addr};
    end else if (ext_en && low_half) begin
      addr = indexed_sum;
    end else if (low_half) begin
      addr = {{BANK_W{1'b0}}, file_addr};
    end else begin
      addr = {{BANK_W{1'b1}}, file_addr};
    end
  end
endmodule

// File: rtl/btg_sequencer.sv
module btg_sequencer (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output btg_pkg::phase_t   phase
);
  import btg_pkg::*;

  phase_t phase_d;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE:   if (go) phase_d = PH_DECODE;
      PH_DECODE: phase_d = PH_READ;
      PH_READ:   phase_d = PH_PROC;
      PH_PROC:   phase_d = PH_WRITE;
      PH_WRITE:  phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE) |-> ($past(phase) == PH_PROC)); // R6
  AST_DECODE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECODE) |-> ($past(phase) == PH_IDLE)); // R7
endmodule

// File: rtl/btg_exec_unit.sv
module btg_exec_unit #(
  parameter int BANK_W  = 3,
  parameter int FILE_W  = 8,
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 16,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic               ext_en,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic [ADDR_W-1:0]  index_reg,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd_en,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_wr_en,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               busy,
  output logic               done
);
  import btg_pkg::*;

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  logic              is_toggle;
  logic              bank_mode;
  logic [FILE_W-1:0] file_addr;
  logic [DATA_W-1:0] mask_n;
  logic [ADDR_W-1:0] addr_n;
  logic              accept;
  phase_t            phase;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;
  logic              proc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  btg_decode #(.DATA_W(DATA_W), .FILE_W(FILE_W), .INSTR_W(INSTR_W)) u_decode (
    .instr     (instr),
    .is_toggle (is_toggle),
    .bank_mode (bank_mode),
    .file_addr (file_addr),
    .bit_mask  (mask_n)
  );

  btg_addr_gen #(.BANK_W(BANK_W), .FILE_W(FILE_W)) u_addr (
    .bank_mode (bank_mode),
    .ext_en    (ext_en),
    .file_addr (file_addr),
    .bank_sel  (bank_sel),
    .index_reg (index_reg),
    .addr      (addr_n)
  );

  assign accept = start && is_toggle && (phase == PH_IDLE);

  btg_sequencer u_seq (
    .clk   (clk),
    .rst_n (core_rst_n),
    .go    (accept),
    .phase (phase)
  );

  assign cap_en  = accept;
  assign proc_en = (phase == PH_PROC);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_n;
      mask_q <= mask_n;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  data_q <= '0;
    else if (proc_en) data_q <= mem_rdata ^ mask_q;
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_rd_en = (phase == PH_READ);
  assign mem_wr_en = (phase == PH_WRITE);
  assign done      = (phase == PH_DONE);
  assign busy      = (phase != PH_IDLE);

  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_rd_en |-> ##2 mem_wr_en); // R6
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_wr_en |-> (mem_addr == $past(mem_addr, 2))); // R8
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ $past(mem_rdata)) == 1)); // R2
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_wr_en |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!core_rst_n)
    done |=> (!done && !busy)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (busy && !done) |=> busy); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !core_rst_n |-> (!busy && !mem_rd_en && !mem_wr_en && !done)); // R9
endmodule

// File: tb/btg_exec_unit_bench.sv
module btg_exec_unit_bench;
  localparam int BANK_W = 3;
  localparam int FILE_W = 8;
  localparam int ADDR_W = BANK_W + FILE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [15:0]       instr;
  logic              ext_en;
  logic [BANK_W-1:0] bank_sel;
  logic [ADDR_W-1:0] index_reg;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd_en;
  logic [7:0]        mem_rdata;
  logic              mem_wr_en;
  logic [7:0]        mem_wdata;
  logic              busy;
  logic              done;

  logic [7:0] ram     [DEPTH];
  logic [7:0] ref_mem [DEPTH];
  int vectors;
  int errors;
  int cyc;

  btg_exec_unit u_btg_exec_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .ext_en(ext_en),
    .bank_sel(bank_sel), .index_reg(index_reg), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= i[7:0];
      mem_rdata <= 8'h00;
    end else begin
      if (mem_wr_en) ram[mem_addr] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [15:0] ins,
      input logic [BANK_W-1:0] bk, input logic [ADDR_W-1:0] ix, input logic ex);
    logic [7:0] f;
    f = ins[7:0];
    if (ins[8])              return {bk, f};
    if (ex && f <= 8'h5F)    return ix + {{BANK_W{1'b0}}, f};
    if (f <= 8'h5F)          return {{BANK_W{1'b0}}, f};
    return {{BANK_W{1'b1}}, f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors = vectors + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [15:0] ins, input logic [BANK_W-1:0] bk,
                       input logic [ADDR_W-1:0] ix, input logic ex, input string tag);
    logic [ADDR_W-1:0] ea;
    logic [7:0] ew;
    ea = exp_addr(ins, bk, ix, ex);
    ew = ref_mem[ea] ^ (8'h01 << ins[11:9]);
    instr = ins; bank_sel = bk; index_reg = ix; ext_en = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !mem_rd_en && !mem_wr_en, "R6 decode", {busy, mem_rd_en, mem_wr_en}, 3'b100);
    // R7 / R8: disturb inputs and strobe start while busy
    instr = {4'b0111, 12'($urandom)}; bank_sel = BANK_W'($urandom);
    index_reg = ADDR_W'($urandom); ext_en = 1'($urandom); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd_en && mem_addr == ea, tag, mem_addr, ea);
    @(negedge clk);
    chk(!mem_rd_en && !mem_wr_en, "R6 process", {mem_rd_en, mem_wr_en}, 0);
    @(negedge clk);
    chk(mem_wr_en && mem_addr == ea && mem_wdata == ew, "R2 R8 write",
        {mem_addr, mem_wdata}, {ea, ew});
    ref_mem[ea] = ew;
    @(negedge clk);
    chk(done && busy, "R6 done", {done, busy}, 2'b11);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R6 R7 idle", {done, busy}, 2'b00);
  endtask

  initial begin
    logic [15:0] ins;
    logic [7:0]  f;
    vectors = 0; errors = 0; cyc = 0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = i[7:0];
    rst_n = 1'b0; start = 1'b0; instr = '0; ext_en = 1'b0; bank_sel = '0; index_reg = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R9 reset",
        {busy, done, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R9 after release", {busy, done}, 0);

    // R2 directed: 0x75, bit 4 -> 0x65 (bank 0, file 0x75 holds 0x75)
    do_op({4'b0111, 3'd4, 1'b1, 8'h75}, 3'd0, '0, 1'b0, "R3 directed");
    chk(ref_mem[11'h075] == 8'h65, "R2 0x75 toggled", ref_mem[11'h075], 8'h65);

    // R1: foreign opcode ignored
    instr = 16'h6345; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !mem_rd_en && !mem_wr_en, "R1 bad opcode",
          {busy, mem_rd_en, mem_wr_en}, 0);
      @(negedge clk);
    end

    // R4 / R5 boundaries and indexed wrap
    do_op({4'b0111, 3'd0, 1'b0, 8'h5F}, 3'd5, 11'h123, 1'b0, "R4 file 0x5F");
    do_op({4'b0111, 3'd1, 1'b0, 8'h60}, 3'd5, 11'h123, 1'b0, "R4 file 0x60");
    do_op({4'b0111, 3'd2, 1'b0, 8'h60}, 3'd5, 11'h123, 1'b1, "R4 ext file 0x60");
    do_op({4'b0111, 3'd3, 1'b0, 8'h5F}, 3'd5, 11'h7F0, 1'b1, "R5 wrap");
    do_op({4'b0111, 3'd7, 1'b0, 8'h00}, 3'd5, 11'h3FF, 1'b1, "R5 zero offset");

    // every bit, every mode, twice
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 8; b++) begin
        for (int r = 0; r < 2; r++) begin
          f = 8'($urandom);
          case (m)
            0: ins = {4'b0111, 3'(b), 1'b1, f};
            1: ins = {4'b0111, 3'(b), 1'b0, 8'(f % 8'h60)};
            2: ins = {4'b0111, 3'(b), 1'b0, 8'(8'h60 + f % 8'hA0)};
            default: ins = {4'b0111, 3'(b), 1'b0, 8'(f % 8'h60)};
          endcase
          do_op(ins, BANK_W'($urandom), ADDR_W'($urandom), (m == 3),
                m == 0 ? "R3 bank" : (m == 3 ? "R5 indexed" : "R4 access"));
        end
      end
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      do_op({4'b0111, 12'($urandom)}, BANK_W'($urandom), ADDR_W'($urandom),
            1'($urandom), "R3 R4 R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule